// File: doc/BRIEF.md
# Register Write Unlock Sequencer

This block guards a small bank of memory-mapped registers against accidental writes. It watches every write on a simple register bus, with its byte address, byte enables and data. A protected register may only be written right after software has put a two-byte key into the key location. Each byte of the key must be written alone, as a one-byte access. A write to a protected register that does not follow a complete key is blocked: the bank never sees a strobe for it.

Software unlocks the bank by writing 0x80 and then 0x86 as single bytes to byte lane 0 of address 0x0C. The next bus write, whatever it is, uses up the unlock. If that write targets a protected register, the block raises a one-cycle permit strobe in the following clock cycle. With the strobe come a one-hot register select and the captured data and byte enables. A permitted write that sets bit 8 of the register at 0x0C also gives a one-cycle reload pulse, which the timer logic uses to restart its count.

Top module: `wr_unlock_guard`

## Requirements
- R1: After reset the block is locked: `pw_valid`, `pw_sel` and `reload_pulse` are 0. A protected write issued straight after reset is blocked.
- R2: The key is two writes to address 0x0C with `wr_be` = 4'b0001: first data byte 0x80, then 0x86. After the key, a write to a protected register makes `pw_valid` high for exactly one cycle, in the cycle after the write. In that same cycle `pw_sel` is one-hot and `pw_data`/`pw_be` equal the written values. The select bits are: bit 0 for address 0x0C, bit 1 for 0x00 and bit 2 for 0x04.
- R3: A write to a protected register that does not come right after a complete key gives no `pw_valid`.
- R4: One unlock allows exactly one write. A second protected write needs the whole key again.
- R5: Any write between the two key bytes restarts the sequence, so a later 0x86 does not unlock. This covers a write to another address and a non-key byte written to the key lane.
- R6: Only a one-byte write in lane 0 counts as a key write. A wider access, or a byte in another lane, does not advance the sequence and restarts it.
- R7: A 0x86 with no 0x80 just before it does not unlock. A repeated 0x80 counts as a fresh first key byte, so 0x80, 0x80, 0x86 does unlock.
- R8: After unlocking, a write to an address that is not protected uses up the unlock and produces no `pw_valid`.
- R9: `reload_pulse` goes high together with `pw_valid` only when the permitted write targets address 0x0C, enables byte lane 1 and has data bit 8 set. Otherwise it stays 0.
- R10: The key writes themselves never produce `pw_valid`.
- R11: Cycles with `wr_en` low leave the sequence unchanged, so idle cycles may come between key bytes and before the protected write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in sync with clk |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 8 | Byte address of the addressed word |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| pw_valid | output | 1 | One-cycle permitted-write strobe to the register bank |
| pw_sel | output | 3 | One-hot protected register select; zero when pw_valid is low |
| pw_be | output | 4 | Byte enables of the permitted write |
| pw_data | output | 32 | Data of the permitted write |
| reload_pulse | output | 1 | One-cycle timer reload request |

## Verification
The bench builds the block with its default parameters: a 32-bit data bus with four byte lanes, 8-bit addresses, three protected registers at 0x0C, 0x00 and 0x04, and reload bit 8. With four lanes the bench can send key values in the wrong lane and as wider accesses, not only as proper single-byte writes. Because the reload register shares its address with the key, the bench can also check that a key byte is never mistaken for a permitted write to that register, and that bit 8 in lane 1 is picked out correctly.

// File: rtl/wr_unlock_pkg.sv
package wr_unlock_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } lock_state_e;

endpackage

// File: rtl/ulk_key_match.sv
module ulk_key_match #(
  parameter int unsigned            ADDR_W     = 8,
  parameter int unsigned            BE_W       = 4,
  parameter logic [ADDR_W-1:0]      KEY_ADDR   = 8'h0C,
  parameter int unsigned            KEY_LANE   = 0,
  parameter logic [7:0]             KEY_FIRST  = 8'h80,
  parameter logic [7:0]             KEY_SECOND = 8'h86
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [7:0]        lane_byte,
  output logic              hit_first,
  output logic              hit_second
);

  localparam logic [BE_W-1:0] LANE_MASK = BE_W'(1) << KEY_LANE;

  logic single_key_byte;

  always_comb begin
    single_key_byte = (addr == KEY_ADDR) && (be == LANE_MASK);
    hit_first       = single_key_byte && (lane_byte == KEY_FIRST);
    hit_second      = single_key_byte && (lane_byte == KEY_SECOND);
  end

endmodule

// File: rtl/ulk_prot_decode.sv
module ulk_prot_decode #(
  parameter int unsigned                   ADDR_W     = 8,
  parameter int unsigned                   NUM_PROT   = 3,
  parameter logic [NUM_PROT*ADDR_W-1:0]    PROT_ADDRS = {8'h04, 8'h00, 8'h0C}
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_PROT-1:0] sel,
  output logic                any_hit
);

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_cmp
    assign sel[g] = (addr == PROT_ADDRS[g*ADDR_W +: ADDR_W]);
  end

  assign any_hit = |sel;

endmodule

// File: rtl/ulk_fsm.sv
module ulk_fsm
  import wr_unlock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        hit_first,
  input  logic        hit_second,
  output lock_state_e state_q,
  output logic        open_o
);

  lock_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      unique case (state_q)
        ST_LOCKED: state_d = hit_first ? ST_ARMED : ST_LOCKED;
        ST_ARMED: begin
          if (hit_second)     state_d = ST_OPEN;
          else if (hit_first) state_d = ST_ARMED;
          else                state_d = ST_LOCKED;
        end
        ST_OPEN:   state_d = ST_LOCKED;
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == ST_OPEN);

  p_open_from_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_OPEN) |-> $past(state_q == ST_ARMED));

  p_open_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPEN && wr_en) |=> (state_q == ST_LOCKED));

  p_nonkey_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_first && !hit_second && state_q != ST_OPEN) |=> (state_q == ST_LOCKED));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q));

endmodule

// File: rtl/wr_unlock_guard.sv
module wr_unlock_guard
  import wr_unlock_pkg::*;
#(
  parameter int unsigned                ADDR_W     = 8,
  parameter int unsigned                DATA_W     = 32,
  parameter int unsigned                NUM_PROT   = 3,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = {8'h04, 8'h00, 8'h0C},
  parameter logic [ADDR_W-1:0]          KEY_ADDR   = 8'h0C,
  parameter int unsigned                KEY_LANE   = 0,
  parameter logic [7:0]                 KEY_FIRST  = 8'h80,
  parameter logic [7:0]                 KEY_SECOND = 8'h86,
  parameter int unsigned                RELOAD_IDX = 0,
  parameter int unsigned                RELOAD_BIT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W/8-1:0]    wr_be,
  input  logic [DATA_W-1:0]      wr_data,
  output logic                   pw_valid,
  output logic [NUM_PROT-1:0]    pw_sel,
  output logic [DATA_W/8-1:0]    pw_be,
  output logic [DATA_W-1:0]      pw_data,
  output logic                   reload_pulse
);

  localparam int unsigned BE_W        = DATA_W / 8;
  localparam int unsigned RELOAD_LANE = RELOAD_BIT / 8;

  logic                hit_first;
  logic                hit_second;
  logic [NUM_PROT-1:0] prot_sel;
  logic                prot_any;
  logic                open;
  lock_state_e         state;

  logic                permit_d;
  logic                reload_d;
  logic [NUM_PROT-1:0] sel_d;

  ulk_key_match #(
    .ADDR_W    (ADDR_W),
    .BE_W      (BE_W),
    .KEY_ADDR  (KEY_ADDR),
    .KEY_LANE  (KEY_LANE),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .addr      (wr_addr),
    .be        (wr_be),
    .lane_byte (wr_data[KEY_LANE*8 +: 8]),
    .hit_first (hit_first),
    .hit_second(hit_second)
  );

  ulk_prot_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_PROT  (NUM_PROT),
    .PROT_ADDRS(PROT_ADDRS)
  ) u_dec (
    .addr   (wr_addr),
    .sel    (prot_sel),
    .any_hit(prot_any)
  );

  ulk_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .hit_first (hit_first),
    .hit_second(hit_second),
    .state_q   (state),
    .open_o    (open)
  );

  // Next-state of the grant outputs.
  always_comb begin
    permit_d = wr_en && open && prot_any;
    sel_d    = permit_d ? prot_sel : '0;
    reload_d = permit_d && prot_sel[RELOAD_IDX]
               && wr_be[RELOAD_LANE] && wr_data[RELOAD_BIT];
  end

  // Strobes and select: updated every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_valid     <= 1'b0;
      pw_sel       <= '0;
      reload_pulse <= 1'b0;
    end else begin
      pw_valid     <= permit_d;
      pw_sel       <= sel_d;
      reload_pulse <= reload_d;
    end
  end

  // Payload: loaded only on a granted write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_be   <= '0;
      pw_data <= '0;
    end else if (permit_d) begin
      pw_be   <= wr_be;
      pw_data <= wr_data;
    end
  end

  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid |=> !pw_valid);

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid |-> ($countones(pw_sel) == 1));

  p_reload_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |-> (pw_valid && pw_sel[RELOAD_IDX]));

  p_grant_needs_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pw_valid) |-> $past(state == ST_OPEN));

endmodule

// File: tb/wr_unlock_guard_bench.sv
module wr_unlock_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic        pw_valid;
  logic [2:0]  pw_sel;
  logic [3:0]  pw_be;
  logic [31:0] pw_data;
  logic        reload_pulse;

  int n_checks = 0;
  int n_errors = 0;

  logic        o_valid;
  logic [2:0]  o_sel;
  logic [3:0]  o_be;
  logic [31:0] o_data;
  logic        o_reload;

  always #4 clk = ~clk;

  wr_unlock_guard u_wr_unlock_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .pw_valid    (pw_valid),
    .pw_sel      (pw_sel),
    .pw_be       (pw_be),
    .pw_data     (pw_data),
    .reload_pulse(reload_pulse)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bus write; outputs captured 1 ns after the edge that registers it.
  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(posedge clk);
    #1;
    o_valid = pw_valid; o_sel = pw_sel; o_be = pw_be;
    o_data = pw_data; o_reload = reload_pulse;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock(input string req);
    wr(8'h0C, 4'h1, 32'h80);
    chk(req, "no grant on first key byte (R10)", 32'(o_valid), 0);
    wr(8'h0C, 4'h1, 32'h86);
    chk(req, "no grant on second key byte (R10)", 32'(o_valid), 0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "pw_valid after reset", 32'(pw_valid), 0);
    chk("R1", "pw_sel after reset", 32'(pw_sel), 0);
    chk("R1", "reload after reset", 32'(reload_pulse), 0);
    wr(8'h00, 4'hF, 32'hDEAD0001);
    chk("R1", "protected write right after reset blocked", 32'(o_valid), 0);
  endtask

  task automatic t_basic;
    unlock("R2");
    wr(8'h00, 4'hF, 32'h12345678);
    chk("R2", "grant after key", 32'(o_valid), 1);
    chk("R2", "select for 0x00", 32'(o_sel), 32'h2);
    chk("R2", "granted data", o_data, 32'h12345678);
    chk("R2", "granted be", 32'(o_be), 32'hF);
    idle(1); #5;
    chk("R2", "grant lasts one cycle", 32'(pw_valid), 0);
    wr(8'h00, 4'hF, 32'h0BAD0BAD);
    chk("R4", "second write after one unlock blocked", 32'(o_valid), 0);
  endtask

  task automatic t_locked;
    wr(8'h04, 4'hF, 32'h00000111);
    chk("R3", "locked write to 0x04 blocked", 32'(o_valid), 0);
    wr(8'h0C, 4'h2, 32'h00000100);
    chk("R3", "locked write to 0x0C blocked", 32'(o_valid), 0);
    chk("R9", "no reload without unlock", 32'(o_reload), 0);
  endtask

  task automatic t_stray;
    wr(8'h0C, 4'h1, 32'h80);
    wr(8'h20, 4'h1, 32'h11);
    wr(8'h0C, 4'h1, 32'h86);
    wr(8'h00, 4'hF, 32'h1);
    chk("R5", "other-address write between key bytes", 32'(o_valid), 0);
    wr(8'h0C, 4'h1, 32'h80);
    wr(8'h0C, 4'h1, 32'h55);
    wr(8'h0C, 4'h1, 32'h86);
    wr(8'h04, 4'hF, 32'h2);
    chk("R5", "wrong key byte between key bytes", 32'(o_valid), 0);
  endtask

  task automatic t_wide;
    wr(8'h0C, 4'h3, 32'h00000080);
    wr(8'h0C, 4'h1, 32'h86);
    wr(8'h00, 4'hF, 32'h3);
    chk("R6", "wide first key byte ignored", 32'(o_valid), 0);
    wr(8'h0C, 4'h1, 32'h80);
    wr(8'h0C, 4'hF, 32'h00000086);
    wr(8'h0C, 4'h1, 32'h86);
    wr(8'h00, 4'hF, 32'h4);
    chk("R6", "wide second key byte restarts", 32'(o_valid), 0);
    wr(8'h0C, 4'h2, 32'h00008000);
    wr(8'h0C, 4'h1, 32'h86);
    wr(8'h04, 4'hF, 32'h5);
    chk("R6", "key byte in lane 1 ignored", 32'(o_valid), 0);
  endtask

  task automatic t_order;
    wr(8'h0C, 4'h1, 32'h86);
    wr(8'h00, 4'hF, 32'h6);
    chk("R7", "lone second key byte", 32'(o_valid), 0);
    wr(8'h0C, 4'h1, 32'h86);
    wr(8'h0C, 4'h1, 32'h80);
    wr(8'h00, 4'hF, 32'h7);
    chk("R7", "reversed key", 32'(o_valid), 0);
    wr(8'h0C, 4'h1, 32'h80);
    wr(8'h0C, 4'h1, 32'h80);
    wr(8'h0C, 4'h1, 32'h86);
    wr(8'h04, 4'hF, 32'hCAFE0004);
    chk("R7", "repeated first byte then second unlocks", 32'(o_valid), 1);
    chk("R7", "select for 0x04", 32'(o_sel), 32'h4);
  endtask

  task automatic t_consume;
    unlock("R8");
    wr(8'h30, 4'hF, 32'h8);
    chk("R8", "unprotected write not granted", 32'(o_valid), 0);
    wr(8'h00, 4'hF, 32'h9);
    chk("R8", "unlock used by unprotected write", 32'(o_valid), 0);
  endtask

  task automatic t_reload;
    unlock("R9");
    wr(8'h0C, 4'h2, 32'h00000100);
    chk("R9", "reload write granted", 32'(o_valid), 1);
    chk("R9", "select for 0x0C", 32'(o_sel), 32'h1);
    chk("R9", "reload pulse", 32'(o_reload), 1);
    idle(1); #5;
    chk("R9", "reload pulse one cycle", 32'(reload_pulse), 0);
    unlock("R9");
    wr(8'h0C, 4'h2, 32'h00000000);
    chk("R9", "granted without bit 8", 32'(o_valid), 1);
    chk("R9", "no reload without bit 8", 32'(o_reload), 0);
    unlock("R9");
    wr(8'h0C, 4'h1, 32'h00000100);
    chk("R9", "no reload when lane 1 disabled", 32'(o_reload), 0);
    unlock("R9");
    wr(8'h04, 4'hF, 32'h00000100);
    chk("R9", "no reload for other register", 32'(o_reload), 0);
  endtask

  task automatic t_idle;
    wr(8'h0C, 4'h1, 32'h80);
    idle(5);
    wr(8'h0C, 4'h1, 32'h86);
    idle(3);
    wr(8'h04, 4'h3, 32'h0000BEEF);
    chk("R11", "idle cycles keep sequence", 32'(o_valid), 1);
    chk("R11", "granted be", 32'(o_be), 32'h3);
    chk("R11", "granted data", o_data, 32'h0000BEEF);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_locked;
    t_stray;
    t_wide;
    t_order;
    t_consume;
    t_reload;
    t_idle;
    idle(2);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule